// File: doc/BRIEF.md
# SPI Flash Master Serial Clock and Chip-Select Generator

This block produces the serial clock and the active-low chip selects for an SPI flash master. It also emits the shift and sample strobes that a neighbouring byte shifter needs. A 32-bit control word sets every option, and a separate enable input gates the whole block. A transfer runs one byte at a time.

The serial clock is the reference clock divided by a power of two. Its idle level and the clock edge on which data is captured are both selectable. Chip selects either follow the transfer or are held by a force bit. A byte is sent whenever queued data is flagged, unless manual start is on; then the block waits for an explicit go bit. The divisor is sampled only when a byte begins.

Top module: `qspi_sclk_gen`

## Requirements
- R1: After reset the serial clock is low, every chip select is high, and no shift, sample or byte-done strobe is active.
- R2: During a byte, each high phase and each low phase of the serial clock lasts 2^D reference cycles, where D is control bits [5:3], so the period is (2 << D) cycles for D from 0 to 7.
- R3: Whenever no byte is in flight, the serial clock rests at the level of control bit 1 (polarity).
- R4: With control bit 2 (phase) at 0, a sample strobe comes with every leading clock transition. A shift strobe comes with the start of the byte and with every trailing transition except the last. That gives eight of each per byte.
- R5: With control bit 2 at 1, a shift strobe comes with every leading transition and a sample strobe with every trailing transition, eight of each per byte.
- R6: With control bit 14 at 0, the chip-select outputs equal control bits [10 +: NUM_CS] (active low) while a byte or a back-to-back burst runs. Between bursts they are all high.
- R7: With control bit 14 at 1 and the block active, the chip-select outputs follow control bits [10 +: NUM_CS] one cycle later, whether or not a transfer runs. All ones deselects every device.
- R8: With control bit 15 at 1, queued data is not sent until a cycle in which control bit 16 is 1. That trigger starts one burst. A new burst then needs a new trigger. With bit 15 at 0, queued data starts a byte at once.
- R9: A change of the divisor field during a byte does not alter that byte. The next byte runs at the new rate, and the gap before its first edge also uses the new rate.
- R10: When the enable input or control bit 0 (master) drops, the clock returns to the polarity level and all chip selects go high on the next cycle. No strobe is produced until the block is re-enabled and data is queued.
- R11: Every byte has exactly 16 clock transitions and one byte-done pulse on its final transition. If data is still queued at that transition, the next byte starts with no release of chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWord | input | 32 | Control word (bit fields as in the requirements) |
| enable | input | 1 | Block enable |
| txReq | input | 1 | Queued data available for the next byte |
| sclk | output | 1 | Serial clock to the flash |
| csN | output | NUM_CS | Active-low chip selects |
| shiftStb | output | 1 | Shifter should present the next bit |
| sampleStb | output | 1 | Shifter should capture the incoming bit |
| byteDone | output | 1 | Pulse on the final edge of a byte |

## Verification
The two events that share one cycle are the final edge of a byte and the start of the next byte. The next byte's start is where the divisor is reloaded and, at phase 0, the first shift strobe fires. The bench provokes this by changing the divisor part-way through a byte while keeping data queued. It then logs every clock half-period: fifteen at the old rate, followed by the gap and fifteen more at the new rate. It also checks that chip select is released only once and that no strobe lands on an edge of the wrong type. A second collision, the enable dropping in the middle of a half-period, is judged by the clock level and chip selects on the very next cycle.

// File: rtl/qspi_sclk_pkg.sv
package qspi_sclk_pkg;

  // Control word bit positions
  localparam int POS_MASTER = 0;
  localparam int POS_CPOL   = 1;
  localparam int POS_CPHA   = 2;
  localparam int POS_DIV    = 3;
  localparam int POS_SS     = 10;
  localparam int POS_FORCE  = 14;
  localparam int POS_MANUAL = 15;
  localparam int POS_GO     = 16;

  // Strobes from sequencer to clock/select datapath
  typedef struct packed {
    logic load;    // new byte begins: reload divisor and half counter
    logic toggle;  // serial clock edge this cycle
    logic shift;   // shift strobe to register
    logic sample;  // sample strobe to register
    logic done;    // final edge of the byte
    logic selOn;   // chip select should be asserted next cycle
    logic idle;    // force clock to polarity level
  } seqStrobe_t;

endpackage

// File: rtl/qspi_seq_ctrl.sv
module qspi_seq_ctrl
  import qspi_sclk_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       cpha,
  input  logic       manual,
  input  logic       trigger,
  input  logic       forceSel,
  input  logic       txReq,
  input  logic       halfExp,
  output seqStrobe_t stb
);

  localparam int EDGES  = 2 * BYTE_BITS;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic              running;
  logic              armed;
  logic [EDGE_W-1:0] edgeCnt;

  logic go, edgeNow, lastEdge, leading, startNow, runNext;

  always_comb begin
    go       = active && txReq && (!manual || armed || trigger);
    edgeNow  = active && running && halfExp;
    lastEdge = edgeNow && (edgeCnt == LAST_EDGE);
    leading  = !edgeCnt[0];
    startNow = go && (!running || lastEdge);
    runNext  = active && (startNow || (running && !lastEdge));
  end

  always_comb begin
    stb.load   = startNow;
    stb.toggle = edgeNow;
    stb.shift  = (startNow && !cpha) ||
                 (edgeNow && (cpha ? leading : (!leading && !lastEdge)));
    stb.sample = edgeNow && (cpha ? !leading : leading);
    stb.done   = lastEdge;
    stb.selOn  = active && (forceSel || runNext);
    stb.idle   = !runNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      edgeCnt <= '0;
    end else begin
      running <= runNext;
      if (startNow)     edgeCnt <= '0;
      else if (edgeNow) edgeCnt <= edgeCnt + EDGE_W'(1);
    end
  end

  // Manual-start arm: one trigger covers one burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         armed <= 1'b0;
    else if (!active || !manual)       armed <= 1'b0;
    else if (trigger)                  armed <= 1'b1;
    else if (lastEdge && !go)          armed <= 1'b0;
  end

endmodule

// File: rtl/qspi_clk_path.sv
module qspi_clk_path
  import qspi_sclk_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int DIV_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [DIV_BITS-1:0] divSel,
  input  logic                cpol,
  input  logic [NUM_CS-1:0]   ssSel,
  output logic                halfExp,
  output logic                sclk,
  output logic [NUM_CS-1:0]   csN,
  output logic                shiftStb,
  output logic                sampleStb,
  output logic                byteDone
);

  localparam int HALF_W = 1 << DIV_BITS;

  logic [DIV_BITS-1:0] divHeld;
  logic [HALF_W-1:0]   halfCnt;
  logic [HALF_W-1:0]   halfLimit;

  assign halfLimit = (HALF_W'(1) << divHeld) - HALF_W'(1);
  assign halfExp   = (halfCnt == halfLimit);

  // Divisor is captured only when a byte begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHeld <= '0;
      halfCnt <= '0;
    end else if (stb.load) begin
      divHeld <= divSel;
      halfCnt <= '0;
    end else if (halfExp) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sclk <= 1'b0;
    else if (stb.idle)    sclk <= cpol;
    else if (stb.toggle)  sclk <= ~sclk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftStb  <= 1'b0;
      sampleStb <= 1'b0;
      byteDone  <= 1'b0;
    end else begin
      shiftStb  <= stb.shift;
      sampleStb <= stb.sample;
      byteDone  <= stb.done;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) csN[i] <= 1'b1;
      else       csN[i] <= stb.selOn ? ssSel[i] : 1'b1;
    end
  end

endmodule

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen
  import qspi_sclk_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int DIV_BITS  = 3,
  parameter int BYTE_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgWord,
  input  logic              enable,
  input  logic              txReq,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic              shiftStb,
  output logic              sampleStb,
  output logic              byteDone
);

  seqStrobe_t stb;
  logic       halfExp;
  logic       active;
  logic       unusedCfg;

  assign active    = enable && cfgWord[POS_MASTER];
  assign unusedCfg = ^cfgWord;

  qspi_seq_ctrl #(.BYTE_BITS(BYTE_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .active   (active),
    .cpha     (cfgWord[POS_CPHA]),
    .manual   (cfgWord[POS_MANUAL]),
    .trigger  (cfgWord[POS_GO]),
    .forceSel (cfgWord[POS_FORCE]),
    .txReq    (txReq),
    .halfExp  (halfExp),
    .stb      (stb)
  );

  qspi_clk_path #(.NUM_CS(NUM_CS), .DIV_BITS(DIV_BITS)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .divSel    (cfgWord[POS_DIV +: DIV_BITS]),
    .cpol      (cfgWord[POS_CPOL]),
    .ssSel     (cfgWord[POS_SS +: NUM_CS]),
    .halfExp   (halfExp),
    .sclk      (sclk),
    .csN       (csN),
    .shiftStb  (shiftStb),
    .sampleStb (sampleStb),
    .byteDone  (byteDone)
  );

endmodule

// File: rtl/qspi_sclk_gen_chk.sv
module qspi_sclk_gen_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       cfgWord,
  input logic              enable,
  input logic              sclk,
  input logic [NUM_CS-1:0] csN,
  input logic              shiftStb,
  input logic              sampleStb,
  input logic              byteDone
);

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && cfgWord[0]) |=> (csN == '1 && !shiftStb && !sampleStb &&
                                 !byteDone && sclk == $past(cfgWord[1])));

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftStb && sampleStb));

  a_r6_cs_in_byte: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWord[14] && $stable(cfgWord) && $stable(enable) && enable &&
     sclk != cfgWord[1]) |-> (csN == cfgWord[10 +: NUM_CS]));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

  a_r7_force_follow: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cfgWord[0] && cfgWord[14]) |=> (csN == $past(cfgWord[10 +: NUM_CS])));

endmodule

bind qspi_sclk_gen qspi_sclk_gen_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWord   (cfgWord),
  .enable    (enable),
  .sclk      (sclk),
  .csN       (csN),
  .shiftStb  (shiftStb),
  .sampleStb (sampleStb),
  .byteDone  (byteDone)
);

// File: tb/qspi_sclk_gen_bench.sv
module qspi_sclk_gen_bench;

  localparam int NCS = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [31:0]    cfgWord;
  logic           enable = 1'b0;
  logic           txReq = 1'b0;
  logic           sclk;
  logic [NCS-1:0] csN;
  logic           shiftStb, sampleStb, byteDone;

  qspi_sclk_gen #(.NUM_CS(NCS)) u_qspi_sclk_gen (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .enable(enable), .txReq(txReq),
    .sclk(sclk), .csN(csN), .shiftStb(shiftStb), .sampleStb(sampleStb),
    .byteDone(byteDone)
  );

  always #4 clk = ~clk;

  int nRun = 0;
  int nFail = 0;

  // monitor state
  int monEpoch = 0, seenEpoch = 0;
  int nToggle, nShift, nSample, nDone, nBad, nCsRel, logN, cyc;
  int halfLog [64];
  logic prevSclk, firstChg, chg, lead, trail, csFell;
  logic [NCS-1:0] prevCs;
  logic curCpol = 1'b0, curCpha = 1'b0;

  always @(negedge clk) begin
    if (seenEpoch != monEpoch) begin
      seenEpoch = monEpoch;
      nToggle = 0; nShift = 0; nSample = 0; nDone = 0; nBad = 0; nCsRel = 0;
      logN = 0; cyc = 0; firstChg = 1'b1; prevSclk = sclk; prevCs = csN;
    end else begin
      cyc++;
      chg = (sclk != prevSclk);
      if (chg) begin
        nToggle++;
        if (!firstChg && logN < 64) begin halfLog[logN] = cyc; logN++; end
        firstChg = 1'b0;
        cyc = 0;
      end
      lead   = chg && (sclk != curCpol);
      trail  = chg && (sclk == curCpol);
      csFell = (prevCs == '1) && (csN != '1);
      if (shiftStb)  nShift++;
      if (sampleStb) nSample++;
      if (byteDone)  nDone++;
      if (sampleStb && !(curCpha ? trail : lead)) nBad++;
      if (shiftStb && !(curCpha ? lead : (trail || csFell))) nBad++;
      if (csN == '1 && prevCs != '1) nCsRel++;
      prevSclk = sclk;
      prevCs   = csN;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun + 1, nFail + 1);
    $finish;
  end

  function automatic logic [31:0] mkCfg(input int mst, div, cpol, cpha, frc, ss, man, go);
    logic [31:0] c;
    c = '0;
    c[0] = mst[0]; c[1] = cpol[0]; c[2] = cpha[0]; c[5:3] = div[2:0];
    c[7:6] = 2'b11; c[10 +: NCS] = ss[NCS-1:0]; c[14] = frc[0];
    c[15] = man[0]; c[16] = go[0]; c[31] = 1'b1;
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clrMon();
    monEpoch++;
    @(negedge clk);
  endtask

  task automatic waitDone(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (byteDone) seen++;
    end
  endtask

  task automatic waitChanges(input int n);
    int ch = 0;
    logic p = sclk;
    while (ch < n) begin
      @(negedge clk);
      if (sclk != p) ch++;
      p = sclk;
    end
  endtask

  task automatic chkHalves(input string tag, input int from, input int upto, input int exp);
    int bad = 0;
    for (int i = from; i < upto; i++) if (halfLog[i] != exp) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    cfgWord = mkCfg(1, 0, 0, 0, 0, 3, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 sclk after reset", sclk, 0);
    chk("R1 csN after reset", csN, 3);
    chk("R1 strobes after reset", {shiftStb, sampleStb, byteDone}, 0);
  endtask

  task automatic t_byte(input int div, input int cpol, input int cpha, input int ss);
    curCpol = cpol[0]; curCpha = cpha[0];
    @(negedge clk);
    cfgWord = mkCfg(1, div, cpol, cpha, 0, ss, 0, 0); enable = 1'b1; txReq = 1'b0;
    repeat (3) @(negedge clk);
    clrMon();
    txReq = 1'b1;
    do @(negedge clk); while (csN == '1);
    chk("R6 csN during byte", csN, ss);
    txReq = 1'b0;
    waitDone(1);
    repeat (3) @(negedge clk);
    chk("R11 toggles per byte", nToggle, 16);
    chk("R11 one byteDone", nDone, 1);
    chk(cpha ? "R5 shift count" : "R4 shift count", nShift, 8);
    chk(cpha ? "R5 sample count" : "R4 sample count", nSample, 8);
    chk(cpha ? "R5 strobe edge type" : "R4 strobe edge type", nBad, 0);
    chk("R2 half periods logged", logN, 15);
    chkHalves("R2 half period length", 0, logN, 1 << div);
    chk("R3 idle level", sclk, cpol);
    chk("R6 csN released", csN, 3);
  endtask

  task automatic t_burst();
    curCpol = 1'b0; curCpha = 1'b1;
    @(negedge clk);
    cfgWord = mkCfg(1, 1, 0, 1, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    clrMon();
    txReq = 1'b1;
    waitDone(2);
    txReq = 1'b0;
    waitDone(1);
    repeat (3) @(negedge clk);
    chk("R11 burst byteDone count", nDone, 3);
    chk("R11 burst toggles", nToggle, 48);
    chk("R5 burst shifts", nShift, 24);
    chk("R5 burst samples", nSample, 24);
    chk("R5 burst edge type", nBad, 0);
    chk("R11 cs held across burst", nCsRel, 1);
    chkHalves("R2 burst half periods", 0, logN, 2);
  endtask

  task automatic t_baud_mid();
    curCpol = 1'b0; curCpha = 1'b0;
    @(negedge clk);
    cfgWord = mkCfg(1, 1, 0, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    clrMon();
    txReq = 1'b1;
    waitChanges(3);
    cfgWord = mkCfg(1, 2, 0, 0, 0, 1, 0, 0);
    waitDone(1);
    txReq = 1'b0;
    waitDone(1);
    repeat (3) @(negedge clk);
    chk("R9 intervals logged", logN, 31);
    chkHalves("R9 first byte keeps old rate", 0, 15, 2);
    chkHalves("R9 second byte uses new rate", 15, 31, 4);
    chk("R9 two bytes", nDone, 2);
    chk("R4 strobes at byte boundary", nBad, 0);
    chk("R4 shifts over two bytes", nShift, 16);
    chk("R11 cs held across boundary", nCsRel, 1);
  endtask

  task automatic t_manual();
    curCpol = 1'b0; curCpha = 1'b0;
    @(negedge clk);
    cfgWord = mkCfg(1, 0, 0, 0, 0, 2, 1, 0);
    repeat (3) @(negedge clk);
    clrMon();
    txReq = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 no clock before trigger", nToggle, 0);
    chk("R8 no select before trigger", csN, 3);
    cfgWord = mkCfg(1, 0, 0, 0, 0, 2, 1, 1);
    @(negedge clk);
    cfgWord = mkCfg(1, 0, 0, 0, 0, 2, 1, 0);
    chk("R8 trigger starts byte", csN, 2);
    txReq = 1'b0;
    waitDone(1);
    repeat (3) @(negedge clk);
    chk("R8 one byte after trigger", nDone, 1);
    txReq = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 trigger consumed", nDone, 1);
    chk("R8 clock idle without new trigger", nToggle, 16);
    txReq = 1'b0;
  endtask

  task automatic t_force();
    @(negedge clk);
    cfgWord = mkCfg(1, 0, 0, 0, 1, 2, 0, 0);
    repeat (2) @(negedge clk);
    clrMon();
    chk("R7 forced select 10", csN, 2);
    cfgWord = mkCfg(1, 0, 0, 0, 1, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk("R7 forced select 01", csN, 1);
    cfgWord = mkCfg(1, 0, 0, 0, 1, 3, 0, 0);
    repeat (2) @(negedge clk);
    chk("R7 all ones deselects", csN, 3);
    chk("R7 no clock while forced idle", nToggle, 0);
    cfgWord = mkCfg(1, 0, 0, 0, 0, 2, 0, 0);
    repeat (2) @(negedge clk);
    chk("R6 auto select idle high", csN, 3);
  endtask

  task automatic t_disable(input bit viaMaster);
    curCpol = 1'b1; curCpha = 1'b0;
    @(negedge clk);
    cfgWord = mkCfg(1, 2, 1, 0, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    txReq = 1'b1;
    waitChanges(5);
    if (viaMaster) cfgWord[0] = 1'b0;
    else           enable = 1'b0;
    txReq = 1'b0;
    @(negedge clk);
    chk("R10 clock back to polarity", sclk, 1);
    chk("R10 selects released", csN, 3);
    clrMon();
    repeat (40) @(negedge clk);
    chk("R10 no toggles while off", nToggle, 0);
    chk("R10 no strobes while off", nShift + nSample + nDone, 0);
    cfgWord[0] = 1'b1; enable = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 idle after re-enable", csN, 3);
    chk("R3 idle level after re-enable", sclk, 1);
    chk("R10 no toggles after re-enable", nToggle, 0);
  endtask

  initial begin
    t_reset();
    t_byte(0, 0, 0, 2);
    t_byte(1, 1, 0, 1);
    t_byte(2, 0, 1, 2);
    t_byte(3, 1, 1, 1);
    t_burst();
    t_baud_mid();
    t_manual();
    t_force();
    t_disable(1'b0);
    t_disable(1'b1);
    t_byte(0, 0, 1, 2);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule